// File: doc/BRIEF.md
# FIFO-fed I2C master transaction engine

This block runs I2C master transactions at byte level. Software queues work in an 8-entry transmit FIFO. Each entry is 9 bits wide. An entry with bit 8 set is an address command: bits 7:1 hold the 7-bit target address and bit 0 is the direction, where 1 means read. An entry with bit 8 clear is a plain data byte. After a start request, the engine emits START and shifts out the address command. It then either sends the queued data bytes, sampling the acknowledge after each one, or receives bytes into an 8-entry receive FIFO. At the end it emits STOP when a stop is requested.

The engine does not time SCL or SDA itself. Each bus action (START, STOP, write one bit, read one bit) goes out as a request on a bit-command handshake. A separate timing block carries out the request and reports completion, the bit it sampled, and whether arbitration was lost. An optional receive byte count lets a read end by itself: the last counted byte is NACKed automatically. A sticky interrupt register, an enable mask and a write-one-to-clear register drive one interrupt line.

Top module: `i2cm_fifo_master`

## Requirements
- R1: After reset, the status word (address 5) reads 0x0003, the interrupt view (address 2) reads 0x0200, `irq_o` is low and no bit command is requested.
- R2: A write to address 1 pushes bits 8:0 into the transmit FIFO, which holds 8 entries. A write to a full FIFO is dropped. Status bit 1 means transmit not full, bit 0 means transmit empty, bit 3 means receive full and bit 2 means receive not empty. A read of address 1 pops the receive FIFO.
- R3: A control write (address 0) with bit 3 (master) and bit 2 set starts a transaction: one START command, then the address entry as 8 write-bit commands MSB first, then one read-bit command for the acknowledge. A bit command stays requested, with the same op code, until `bit_done_i`. Op codes: 0 START, 1 STOP, 2 write bit, 3 read bit.
- R4: In a write transaction, each data entry is sent MSB first and followed by an acknowledge read. When the transmit FIFO is empty, the engine requests nothing until either data arrives or a stop (control bits 3 and 1) is pending. A pending stop waits until the queued data has been sent.
- R5: When the address command has bit 0 set, the engine receives bytes: 8 read-bit commands MSB first, then a write-bit acknowledge driving 0. Each byte is pushed into the receive FIFO.
- R6: When address 7 holds N != 0, the engine drives 1 on the acknowledge of the Nth received byte and sets interrupt bit 4. It then requests nothing until a stop is pending. When address 7 holds 0, the counter is off.
- R7: When the counter is off, control bits 3 and 0 make the engine NACK the next received byte. While the receive FIFO is full, no new byte is started.
- R8: An acknowledge sampled as 1 sets interrupt bit 2. The engine then requests nothing until a stop is pending, then issues STOP. On STOP completion it sets bit 7 for a write transaction or bit 6 for a read transaction.
- R9: A completion that reports arbitration loss sets interrupt bit 1, issues no STOP and returns the engine to idle with device busy clear.
- R10: Status bit 12 (device busy) is set from the start request until STOP completes. Bit 8 (bus busy) is set from START completion until STOP completion. Bit 11 (stop seen) is set when STOP completes and cleared at the next start.
- R11: The interrupt view holds sticky bits 7, 6, 4, 2 and 1, plus level bit 9 (transmit empty) and level bit 8 (receive full). Writing ones to address 4 clears the matching sticky bits. `irq_o` is high when any bit is set in both the view and the enable mask (address 3).
- R12: A write to address 6 flushes the transmit FIFO when bit 2 is set and the receive FIFO when bit 1 is set. Bit 0 forces the engine back to idle with its busy and stop-seen state cleared and all sticky interrupt bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the receive FIFO at address 1) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |
| bit_req_o | output | 1 | Bit command requested |
| bit_op_o | output | 2 | Bit command op code |
| bit_wbit_o | output | 1 | Bit value for a write-bit command |
| bit_done_i | input | 1 | Timing block finished the current command |
| bit_rbit_i | input | 1 | Bit sampled by a read-bit command |
| bit_lost_i | input | 1 | Arbitration lost, valid with `bit_done_i` |

## Verification
The assertions assume that the timing block raises `bit_done_i` only while a command is requested, and for a single cycle. They also assume it reports `bit_lost_i` only together with `bit_done_i`, and that software never writes start and force-reset in the same cycle. The bench models the timing block as a responder that completes every request exactly one cycle after seeing it and then drops `bit_done_i` for one cycle. A target model behind that responder acknowledges, NACKs or supplies read data on a scripted byte index, and it raises arbitration loss only at a chosen command number.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_STOP = 2'd1, OP_WRITE = 2'd2, OP_READ = 2'd3} bit_op_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_LOAD, ST_WBIT, ST_WACK, ST_RBIT, ST_RACK, ST_HOLD, ST_STOP
  } eng_state_e;

  localparam logic [2:0] A_CTRL = 3'd0, A_DATA = 3'd1, A_ISTAT = 3'd2, A_IEN = 3'd3,
                         A_ICLR = 3'd4, A_STAT = 3'd5, A_FLUSH = 3'd6, A_RXCNT = 3'd7;
  localparam int I_TE = 9, I_RF = 8, I_TC = 7, I_RC = 6, I_RB = 4, I_NA = 2, I_AL = 1;
  localparam int S_DB = 12, S_STS = 11, S_BB = 8, S_RFF = 3, S_RNE = 2, S_TNF = 1, S_TFE = 0;
  localparam logic [15:0] STICKY_MASK = 16'h00D6;
endpackage

// File: rtl/i2cm_sync_fifo.sv
module i2cm_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush_i) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && wptr == AW'(g)) mem[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             start_req_i,
  input  logic             stop_req_i,
  input  logic             nack_req_i,
  input  logic [CNT_W-1:0] rx_limit_i,
  input  logic             tx_valid_i,
  input  logic [8:0]       tx_data_i,
  output logic             tx_pop_o,
  input  logic             rx_full_i,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             bit_req_o,
  output bit_op_e          bit_op_o,
  output logic             bit_wbit_o,
  input  logic             bit_done_i,
  input  logic             bit_rbit_i,
  input  logic             bit_lost_i,
  output logic             ev_na_o,
  output logic             ev_al_o,
  output logic             ev_tc_o,
  output logic             ev_rc_o,
  output logic             ev_rb_o,
  output logic             dev_busy_o,
  output logic             bus_busy_o,
  output logic             stop_seen_o
);
  eng_state_e       state;
  logic             start_pend, stop_pend, nack_pend, rd_mode, ack_nack;
  logic [7:0]       shreg;
  logic [2:0]       bitcnt;
  logic [CNT_W-1:0] rx_cnt;
  logic             done, lost, last_cnt;

  assign bit_req_o = state inside {ST_START, ST_STOP, ST_WBIT, ST_WACK, ST_RBIT, ST_RACK};
  always_comb begin
    unique case (state)
      ST_STOP:          bit_op_o = OP_STOP;
      ST_WBIT, ST_RACK: bit_op_o = OP_WRITE;
      ST_WACK, ST_RBIT: bit_op_o = OP_READ;
      default:          bit_op_o = OP_START;
    endcase
  end
  assign bit_wbit_o = (state == ST_WBIT) ? shreg[7] : ack_nack;

  assign done      = bit_done_i && bit_req_o;
  assign lost      = done && bit_lost_i;
  assign last_cnt  = (rx_limit_i != '0) && (rx_cnt == rx_limit_i - 1'b1);
  assign tx_pop_o  = (state == ST_LOAD) && !rd_mode && tx_valid_i;
  assign rx_push_o = (state == ST_RACK) && done && !lost;
  assign rx_data_o = shreg;

  assign ev_al_o = lost;
  assign ev_na_o = (state == ST_WACK) && done && !lost && bit_rbit_i;
  assign ev_rb_o = rx_push_o && last_cnt;
  assign ev_tc_o = (state == ST_STOP) && done && !lost && !rd_mode;
  assign ev_rc_o = (state == ST_STOP) && done && !lost && rd_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || soft_rst_i) begin
      state       <= ST_IDLE;
      start_pend  <= 1'b0;
      stop_pend   <= 1'b0;
      nack_pend   <= 1'b0;
      rd_mode     <= 1'b0;
      ack_nack    <= 1'b0;
      shreg       <= '0;
      bitcnt      <= '0;
      rx_cnt      <= '0;
      dev_busy_o  <= 1'b0;
      bus_busy_o  <= 1'b0;
      stop_seen_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_pend) begin
            state       <= ST_START;
            start_pend  <= 1'b0;
            dev_busy_o  <= 1'b1;
            stop_seen_o <= 1'b0;
            rx_cnt      <= '0;
            rd_mode     <= 1'b0;
          end else begin
            stop_pend <= 1'b0;  // stray stop while idle is dropped
          end
        end
        ST_START: if (done) begin
          bus_busy_o <= 1'b1;
          state      <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!rd_mode) begin
            if (tx_valid_i) begin
              shreg  <= tx_data_i[7:0];
              bitcnt <= '0;
              if (tx_data_i[8]) rd_mode <= tx_data_i[0];
              state  <= ST_WBIT;
            end else if (stop_pend) begin
              stop_pend <= 1'b0;
              state     <= ST_STOP;
            end
          end else if (!rx_full_i) begin
            bitcnt <= '0;
            state  <= ST_RBIT;
          end
        end
        ST_WBIT: if (done) begin
          shreg  <= {shreg[6:0], 1'b0};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) state <= ST_WACK;
        end
        ST_WACK: if (done) state <= bit_rbit_i ? ST_HOLD : ST_LOAD;
        ST_RBIT: if (done) begin
          shreg  <= {shreg[6:0], bit_rbit_i};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            ack_nack <= nack_pend || last_cnt;
            state    <= ST_RACK;
          end
        end
        ST_RACK: if (done) begin
          rx_cnt <= rx_cnt + 1'b1;
          if (ack_nack) begin
            nack_pend <= 1'b0;
            state     <= ST_HOLD;
          end else begin
            state <= ST_LOAD;
          end
        end
        ST_HOLD: if (stop_pend) begin
          stop_pend <= 1'b0;
          state     <= ST_STOP;
        end
        ST_STOP: if (done) begin
          state       <= ST_IDLE;
          dev_busy_o  <= 1'b0;
          bus_busy_o  <= 1'b0;
          stop_seen_o <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      if (lost) begin
        state      <= ST_IDLE;
        dev_busy_o <= 1'b0;
      end
      if (start_req_i) start_pend <= 1'b1;
      if (stop_req_i)  stop_pend  <= 1'b1;
      if (nack_req_i)  nack_pend  <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_fifo_master.sv
module i2cm_fifo_master
  import i2cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o,
  output logic        bit_req_o,
  output logic [1:0]  bit_op_o,
  output logic        bit_wbit_o,
  input  logic        bit_done_i,
  input  logic        bit_rbit_i,
  input  logic        bit_lost_i
);
  logic             wr_ctrl, wr_flush, ctrl_ok, soft_rst;
  logic             tx_push, tx_pop, tx_empty, tx_full, tx_flush;
  logic             rx_push, rx_pop, rx_empty, rx_full, rx_flush;
  logic [8:0]       tx_head;
  logic [7:0]       rx_wdata, rx_head;
  logic [15:0]      int_flags, int_en, int_view, status, ev_vec;
  logic [CNT_W-1:0] rx_limit;
  logic             ev_na, ev_al, ev_tc, ev_rc, ev_rb, dev_busy, bus_busy, stop_seen;
  bit_op_e          op;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_flush = reg_we_i && (reg_addr_i == A_FLUSH);
  assign ctrl_ok  = wr_ctrl && reg_wdata_i[3];
  assign soft_rst = wr_flush && reg_wdata_i[0];
  assign tx_flush = wr_flush && reg_wdata_i[2];
  assign rx_flush = wr_flush && reg_wdata_i[1];
  assign tx_push  = reg_we_i && (reg_addr_i == A_DATA);
  assign rx_pop   = reg_re_i && (reg_addr_i == A_DATA);

  i2cm_sync_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push), .wdata_i(reg_wdata_i[8:0]),
    .pop_i(tx_pop), .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full)
  );

  i2cm_sync_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push), .wdata_i(rx_wdata),
    .pop_i(rx_pop), .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full)
  );

  i2cm_byte_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst),
    .start_req_i(ctrl_ok && reg_wdata_i[2]), .stop_req_i(ctrl_ok && reg_wdata_i[1]),
    .nack_req_i(ctrl_ok && reg_wdata_i[0]), .rx_limit_i(rx_limit),
    .tx_valid_i(!tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_wdata),
    .bit_req_o, .bit_op_o(op), .bit_wbit_o, .bit_done_i, .bit_rbit_i, .bit_lost_i,
    .ev_na_o(ev_na), .ev_al_o(ev_al), .ev_tc_o(ev_tc), .ev_rc_o(ev_rc), .ev_rb_o(ev_rb),
    .dev_busy_o(dev_busy), .bus_busy_o(bus_busy), .stop_seen_o(stop_seen)
  );
  assign bit_op_o = op;

  always_comb begin
    ev_vec       = '0;
    ev_vec[I_TC] = ev_tc;
    ev_vec[I_RC] = ev_rc;
    ev_vec[I_RB] = ev_rb;
    ev_vec[I_NA] = ev_na;
    ev_vec[I_AL] = ev_al;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_flags <= '0;
      int_en    <= '0;
      rx_limit  <= '0;
    end else begin
      if (soft_rst) int_flags <= '0;
      else if (reg_we_i && reg_addr_i == A_ICLR) int_flags <= (int_flags & ~reg_wdata_i) | ev_vec;
      else int_flags <= int_flags | ev_vec;
      if (reg_we_i && reg_addr_i == A_IEN)   int_en   <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_RXCNT) rx_limit <= reg_wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    int_view       = int_flags & STICKY_MASK;
    int_view[I_TE] = tx_empty;
    int_view[I_RF] = rx_full;
    status         = '0;
    status[S_DB]   = dev_busy;
    status[S_STS]  = stop_seen;
    status[S_BB]   = bus_busy;
    status[S_RFF]  = rx_full;
    status[S_RNE]  = !rx_empty;
    status[S_TNF]  = !tx_full;
    status[S_TFE]  = tx_empty;
  end

  assign irq_o = |(int_view & int_en);

  always_comb begin
    unique case (reg_addr_i)
      A_DATA:  reg_rdata_o = {8'h00, rx_head};
      A_ISTAT: reg_rdata_o = int_view;
      A_IEN:   reg_rdata_o = int_en;
      A_STAT:  reg_rdata_o = status;
      A_RXCNT: reg_rdata_o = 16'(rx_limit);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2cm_fifo_master_chk.sv
module i2cm_fifo_master_chk
  import i2cm_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst,
  input logic       bit_req_o,
  input logic [1:0] bit_op_o,
  input logic       bit_wbit_o,
  input logic       bit_done_i,
  input logic       bit_lost_i,
  input logic       dev_busy,
  input logic       rx_push,
  input logic       rx_full,
  input logic       ev_rb
);
  // R3: a request is held with its op code until completion
  p_req_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst)
    (bit_req_o && !bit_done_i) |=> (bit_req_o && $stable(bit_op_o)));

  // R7: receive FIFO is never written while full
  p_no_rx_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> !rx_full);

  // R9: arbitration loss drops to idle with no further command
  p_al_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst)
    (bit_req_o && bit_done_i && bit_lost_i) |=> (!dev_busy && !bit_req_o));

  // R6: count-reached event only on a NACKed acknowledge slot
  p_rb_nack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rb |-> (bit_op_o == OP_WRITE && bit_wbit_o));

  // R10: device busy ends only through STOP completion, loss or forced reset
  p_busy_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_busy) |-> ($past(soft_rst) ||
      ($past(bit_done_i) && ($past(bit_op_o) == OP_STOP || $past(bit_lost_i)))));
endmodule

bind i2cm_fifo_master i2cm_fifo_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst(soft_rst), .bit_req_o(bit_req_o),
  .bit_op_o(bit_op_o), .bit_wbit_o(bit_wbit_o), .bit_done_i(bit_done_i),
  .bit_lost_i(bit_lost_i), .dev_busy(dev_busy), .rx_push(rx_push), .rx_full(rx_full),
  .ev_rb(ev_rb)
);

// File: tb/i2cm_fifo_master_tb.sv
module i2cm_fifo_master_tb;
  import i2cm_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq, bit_req, bit_wbit;
  logic [1:0] bit_op;
  logic bit_done = 0, bit_rbit = 0, bit_lost = 0;

  int checks = 0, fails = 0;
  int pos = 0, wn = 0, an = 0, rn = 0, stop_cnt = 0, op_cnt = 0;
  int lose_at = -1, nack_idx = 255;
  logic [7:0] sh = 0;
  logic [7:0] wlog [16];
  logic       ack_log [16];
  logic [15:0] v;

  // rows: addr7, d0, d1, byte count, NACK'd written-byte index (FF none), expected sticky flags
  localparam logic [47:0] VEC [4] = '{
    48'h50_12_34_02_FF_80,
    48'h21_C3_00_01_00_84,
    48'h7F_FF_00_02_02_84,
    48'h01_80_01_02_FF_80
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_fifo_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .bit_req_o(bit_req),
    .bit_op_o(bit_op), .bit_wbit_o(bit_wbit), .bit_done_i(bit_done),
    .bit_rbit_i(bit_rbit), .bit_lost_i(bit_lost)
  );

  function automatic logic [7:0] src_byte(int k);
    return 8'h3C + 8'(k) * 8'h11;
  endfunction

  // timing block + target model: completes each request one cycle after seeing it
  always @(negedge clk) begin
    if (bit_done) begin
      bit_done = 0;
      bit_lost = 0;
    end else if (bit_req) begin
      bit_done = 1;
      bit_rbit = 0;
      if (op_cnt == lose_at) bit_lost = 1;
      op_cnt++;
      case (bit_op)
        2'd0: pos = 0;
        2'd1: stop_cnt++;
        2'd2: begin
          if (pos < 8) begin
            sh = {sh[6:0], bit_wbit};
            pos++;
            if (pos == 8 && wn < 16) begin wlog[wn] = sh; wn++; end
          end else begin
            if (an < 16) ack_log[an] = bit_wbit;
            an++;
            pos = 0;
          end
        end
        default: begin
          if (pos < 8) begin
            bit_rbit = src_byte(rn)[7-pos];
            pos++;
            if (pos == 8) rn++;
          end else begin
            bit_rbit = (nack_idx == wn - 1);
            pos = 0;
          end
        end
      endcase
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; re = (a == A_DATA);
    #1 d = rdata;
    @(posedge clk); #1 re = 0;
  endtask

  task automatic wait_quiet();
    int q = 0, n = 0;
    while (q < 8 && n < 3000) begin
      @(negedge clk); n++;
      if (bit_req) q = 0; else q++;
    end
  endtask

  task automatic new_txn();
    wr(A_FLUSH, 16'h0006);
    wr(A_ICLR, 16'hFFFF);
    wn = 0; an = 0; rn = 0; stop_cnt = 0; op_cnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(A_STAT, v);  check("R1 status", v, 16'h0003);
    rd(A_ISTAT, v); check("R1 int view", v, 16'h0200);
    check("R1 irq", irq, 0);
    check("R1 no request", bit_req, 0);

    // R3 R4 R8: table of write transactions
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a, d0, d1, nb, nk, ex;
      int exp_wn;
      {a, d0, d1, nb, nk, ex} = VEC[i];
      new_txn();
      nack_idx = nk;
      exp_wn = (nk == 8'hFF) ? int'(nb) + 1 : int'(nk) + 1;
      wr(A_DATA, {7'h01, a[6:0], 1'b0});
      if (nb > 0) wr(A_DATA, {8'h00, d0});
      if (nb > 1) wr(A_DATA, {8'h00, d1});
      wr(A_CTRL, 16'h000E);
      wait_quiet();
      rd(A_ISTAT, v); check("R8 sticky flags", v & 16'h00FE, 16'(ex));
      check("R4 bytes on bus", wn, exp_wn);
      check("R3 address byte", wlog[0], {a[6:0], 1'b0});
      if (exp_wn > 1) check("R4 first data byte", wlog[1], d0);
      check("R8 one stop", stop_cnt, 1);
    end
    nack_idx = 255;

    // R5 R6 counted read of 3 bytes
    new_txn();
    wr(A_RXCNT, 16'd3);
    wr(A_DATA, 16'h0155);
    wr(A_CTRL, 16'h000E);
    wait_quiet();
    rd(A_ISTAT, v); check("R6 RB and RC set", v & 16'h00FE, 16'h0050);
    check("R6 three acks", an, 3);
    check("R5 ack driven 0", {ack_log[0], ack_log[1]}, 2'b00);
    check("R6 last byte NACK", ack_log[2], 1);
    rd(A_STAT, v); check("R2 rx not empty", v[2], 1);
    rd(A_DATA, v); check("R5 byte0", v, 16'h003C);
    rd(A_DATA, v); check("R5 byte1", v, 16'h004D);
    rd(A_DATA, v); check("R5 byte2", v, 16'h005E);
    rd(A_STAT, v); check("R2 rx drained", v[2], 0);

    // R7 manual NACK, receive FIFO full stall
    new_txn();
    wr(A_RXCNT, 16'd0);
    wr(A_DATA, 16'h0155);
    wr(A_CTRL, 16'h000C);
    wait_quiet();
    rd(A_STAT, v);  check("R7 rx full stall", v[3], 1);
    rd(A_ISTAT, v); check("R11 RF level", v[8], 1);
    check("R7 eight bytes before stall", an, 8);
    wr(A_CTRL, 16'h0009);
    wait_quiet();
    check("R7 no byte while full", an, 8);
    rd(A_DATA, v); check("R7 first popped", v, 16'h003C);
    wait_quiet();
    check("R7 ninth byte", an, 9);
    check("R7 ninth NACK", ack_log[8], 1);
    check("R7 eighth ACK", ack_log[7], 0);
    rd(A_ISTAT, v); check("R7 no flags before stop", v & 16'h00FE, 16'h0000);
    wr(A_CTRL, 16'h000A);
    wait_quiet();
    rd(A_ISTAT, v); check("R8 RC only", v & 16'h00FE, 16'h0040);

    // R4 R10 empty-FIFO stall in a write
    new_txn();
    wr(A_DATA, 16'h01A0);
    wr(A_CTRL, 16'h000C);
    wait_quiet();
    check("R4 stalled after address", wn, 1);
    rd(A_STAT, v); check("R10 busy during stall", v & 16'h1900, 16'h1100);
    wr(A_DATA, 16'h005A);
    wait_quiet();
    check("R4 late byte", wlog[1], 8'h5A);
    check("R4 no stop yet", stop_cnt, 0);
    wr(A_CTRL, 16'h000A);
    wait_quiet();
    rd(A_ISTAT, v); check("R8 TC", v & 16'h00FE, 16'h0080);
    rd(A_STAT, v); check("R10 after stop", v & 16'h1900, 16'h0800);

    // R9 arbitration loss during address
    new_txn();
    lose_at = 3;
    wr(A_DATA, 16'h01A0);
    wr(A_DATA, 16'h0011);
    wr(A_CTRL, 16'h000E);
    wait_quiet();
    lose_at = -1;
    rd(A_ISTAT, v); check("R9 AL flag", v & 16'h00FE, 16'h0002);
    check("R9 no stop", stop_cnt, 0);
    rd(A_STAT, v); check("R9 not busy", v[12], 0);

    // R11 interrupt enable and clear
    check("R11 irq masked", irq, 0);
    wr(A_IEN, 16'h0002);
    @(negedge clk); check("R11 irq on AL", irq, 1);
    wr(A_ICLR, 16'h0002);
    @(negedge clk); check("R11 irq cleared", irq, 0);
    wr(A_IEN, 16'h0200);
    @(negedge clk); check("R11 TE masked by pending tx", irq, 0);
    wr(A_FLUSH, 16'h0004);
    @(negedge clk); check("R12 tx flush raises TE", irq, 1);
    wr(A_IEN, 16'h0000);

    // R12 forced reset from a stall
    new_txn();
    wr(A_DATA, 16'h01A0);
    wr(A_CTRL, 16'h000C);
    wait_quiet();
    rd(A_STAT, v); check("R12 busy before force", v[12], 1);
    wr(A_FLUSH, 16'h0001);
    rd(A_STAT, v); check("R12 idle after force", v & 16'h1900, 16'h0000);
    check("R12 no request", bit_req, 0);

    // R2 transmit FIFO depth, ninth write dropped
    new_txn();
    wr(A_DATA, 16'h01A0);
    for (int k = 1; k <= 8; k++) wr(A_DATA, 16'h0010 + 16'(k));
    rd(A_STAT, v); check("R2 tx full status", v & 16'h0003, 16'h0000);
    wr(A_CTRL, 16'h000E);
    wait_quiet();
    check("R2 eight entries sent", wn, 8);
    check("R2 last accepted entry", wlog[7], 8'h17);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule